// File: doc/BRIEF.md
# Fully Associative Translation Cache with Access Permission Check

This block keeps a small set of recently used virtual-to-physical page mappings and answers a translation request in the same cycle it arrives. The virtual page number of the request is compared against the tag of every valid entry at once. On a match the block returns the physical address, formed from the stored physical page number and the untouched page offset, but only if the entry allows the access. A matching entry that forbids the access raises a protection fault instead. With no match, a miss is raised so that an external page-table walker can fetch the mapping.

The walker writes the fetched mapping back through a refill port. The block picks the slot itself. While any slot is empty, the lowest-numbered empty slot is used. Once every slot is full, a rotating pointer names the slot to overwrite, giving first-in first-out replacement. A flush input empties the whole array in one cycle. Each entry also keeps a dirty flag, which the block sets on the first permitted write through that entry. It reports the flag on every hit so that the walker or the operating system can track modified pages.

Top module: `xlat_cache`

## Requirements
- R1: After a synchronous active-low reset no entry is valid, so every request reports a miss.
- R2: A permitted hit raises `pa_valid` in the same cycle as the request, and `pa_addr` equals the entry's physical page number placed above the low `OFF_W` bits of `lk_vaddr`, which pass through unchanged.
- R3: A request (`lk_valid`=1) whose page number matches no valid entry raises `miss` and leaves `pa_valid` and `prot_fault` low.
- R4: A hit is permitted only when the entry's read flag is set for a read (`lk_write`=0) or its write flag is set for a write (`lk_write`=1), and, for a user-mode request (`lk_user`=1), its user flag is also set. A kernel-mode request ignores the user flag. A hit that is not permitted raises `prot_fault` instead of `pa_valid`.
- R5: A permitted write hit sets the entry's dirty flag from the next cycle on. A faulting write leaves the flag unchanged. `hit_dirty` shows the flag of the matched entry on any hit, whether permitted or faulting.
- R6: While any slot is empty, a refill goes to the lowest-numbered empty slot and evicts no valid mapping.
- R7: When every slot is full, a refill overwrites the slot named by the replacement pointer and advances the pointer by one, wrapping after `ENTRIES` slots, so that the oldest mapping is evicted first.
- R8: A flush invalidates every entry and returns the replacement pointer to slot 0 at the next edge. A flush takes priority over a refill in the same cycle.
- R9: With `lk_valid` low, `pa_valid`, `miss`, `prot_fault` and `hit_dirty` are all low.
- R10: At most one of `pa_valid`, `miss` and `prot_fault` is high in any cycle.
- R11: A mapping refilled at one edge is hit by a request for its page number in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Translation request present |
| lk_vaddr | input | VPN_W+OFF_W | Virtual address of the request |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| pa_valid | output | 1 | Permitted hit; `pa_addr` is valid |
| pa_addr | output | PPN_W+OFF_W | Translated physical address (zero when not valid) |
| miss | output | 1 | No valid entry matches the request |
| prot_fault | output | 1 | Matching entry forbids this access |
| hit_dirty | output | 1 | Dirty flag of the matched entry |
| fill_en | input | 1 | Refill strobe |
| fill_vpn | input | VPN_W | Virtual page number of the refilled mapping |
| fill_ppn | input | PPN_W | Physical page number of the refilled mapping |
| fill_rd | input | 1 | Read permitted |
| fill_wr | input | 1 | Write permitted |
| fill_usr | input | 1 | User-mode access permitted |
| fill_dirty | input | 1 | Initial dirty flag |
| flush | input | 1 | Invalidate all entries |

## Verification
Requests are issued with every combination of read or write and kernel or user mode against entries that carry different permission sets. This separates a permitted hit from a protection fault and from a miss. Writes are repeated to the same page before and after a fault, which shows when the dirty flag becomes set and that a faulting write leaves it alone. Refills are issued into an empty array, then past full and through a full wrap of the pointer. Looking up both the oldest and the newest page numbers afterwards shows the slot choice and the eviction order. Flushes are applied with and without a refill in the same cycle. A randomised phase then mixes requests, refills and flushes, and every output is compared in every cycle with a behavioural model.

// File: rtl/xlat_pkg.sv
// Package: types shared by the translation cache modules.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package xlat_pkg;
    // Per-entry permission and status flags.
    typedef struct packed {
        logic rd;   // read allowed
        logic wr;   // write allowed
        logic usr;  // user mode allowed
        logic dty;  // page written since refill
    } page_flags_t;
endpackage

// File: rtl/xlat_perm_check.sv
// Module: combinational permission test for one matched entry.
// Assumes flags come from the entry that matched; kernel mode ignores usr.
module xlat_perm_check
    import xlat_pkg::*;
(
    input  logic        is_write,
    input  logic        is_user,
    input  page_flags_t flags,
    output logic        allow
);
    // Select the access-type flag, then apply the privilege gate.
    always_comb begin
        allow = (is_write ? flags.wr : flags.rd) & (~is_user | flags.usr);
    end
endmodule

// File: rtl/xlat_entry_array.sv
// Module: entry storage with parallel tag compare and an OR-based read mux.
// Assumes at most one valid entry holds any page number (the walker never
// refills a page that is already present).
module xlat_entry_array
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               fill_en,
    input  logic [IDX_W-1:0]   fill_idx,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [PPN_W-1:0]   fill_ppn,
    input  page_flags_t        fill_flags,
    input  logic               mark_en,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic [ENTRIES-1:0] valid_vec,
    output logic               hit,
    output logic [PPN_W-1:0]   hit_ppn,
    output page_flags_t        hit_flags
);
    logic               vld_q [ENTRIES];
    logic [VPN_W-1:0]   tag_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q [ENTRIES];
    page_flags_t        flg_q [ENTRIES];
    logic [ENTRIES-1:0] match;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        // Entry update: flush beats refill, refill beats dirty marking.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[i] <= 1'b0;
                tag_q[i] <= '0;
                ppn_q[i] <= '0;
                flg_q[i] <= '0;
            end else if (flush) begin
                vld_q[i] <= 1'b0;
            end else if (fill_en && fill_idx == IDX_W'(i)) begin
                vld_q[i] <= 1'b1;
                tag_q[i] <= fill_vpn;
                ppn_q[i] <= fill_ppn;
                flg_q[i] <= fill_flags;
            end else if (mark_en && match[i]) begin
                flg_q[i].dty <= 1'b1;
            end
        end
        assign match[i]     = vld_q[i] && (tag_q[i] == lk_vpn);
        assign valid_vec[i] = vld_q[i];
    end

    // Read mux: OR together the fields of the (single) matching entry.
    always_comb begin
        hit_ppn   = '0;
        hit_flags = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            hit_ppn   = hit_ppn | ({PPN_W{match[i]}} & ppn_q[i]);
            hit_flags = hit_flags | ({4{match[i]}} & flg_q[i]);
        end
        hit = |match;
    end

    AST_MARK_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        mark_en |-> hit);  // R5
endmodule

// File: rtl/xlat_victim_sel.sv
// Module: refill slot choice: lowest empty slot, else a FIFO pointer.
// Assumes valid_vec reflects the array state before the current edge.
module xlat_victim_sel #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               fill_en,
    input  logic [ENTRIES-1:0] valid_vec,
    output logic [IDX_W-1:0]   victim_idx
);
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    // Priority search for the lowest-numbered empty slot.
    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) free_idx = IDX_W'(i);
        end
        any_free   = ~&valid_vec;
        victim_idx = any_free ? free_idx : ptr_q;
    end

    // Pointer: cleared by flush, advanced only on a full-array refill.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ptr_q <= '0;
        end else if (fill_en && !any_free) begin
            ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    AST_FREE_SLOT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !(&valid_vec)) |-> !valid_vec[victim_idx]);  // R6
    AST_PTR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ptr_q == '0));  // R8
    AST_PTR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush && (&valid_vec) && ptr_q != IDX_W'(ENTRIES - 1))
        |=> (ptr_q == $past(ptr_q) + 1'b1));  // R7
endmodule

// File: rtl/xlat_cache.sv
// Module: top of the fully associative translation cache.
// Combinational lookup: outputs follow lk_* in the same cycle; refill,
// flush and dirty marking take effect at the next rising edge.
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int OFF_W   = 12,
    localparam int VA_W   = VPN_W + OFF_W,
    localparam int PA_W   = PPN_W + OFF_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             lk_write,
    input  logic             lk_user,
    output logic             pa_valid,
    output logic [PA_W-1:0]  pa_addr,
    output logic             miss,
    output logic             prot_fault,
    output logic             hit_dirty,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_rd,
    input  logic             fill_wr,
    input  logic             fill_usr,
    input  logic             fill_dirty,
    input  logic             flush
);
    logic [VPN_W-1:0]   lk_vpn;
    logic [ENTRIES-1:0] valid_vec;
    logic [IDX_W-1:0]   victim_idx;
    logic               hit;
    logic [PPN_W-1:0]   hit_ppn;
    page_flags_t        hit_flags;
    page_flags_t        fill_flags;
    logic               allow;
    logic               mark_en;

    assign lk_vpn     = lk_vaddr[VA_W-1:OFF_W];
    assign fill_flags = '{rd: fill_rd, wr: fill_wr, usr: fill_usr, dty: fill_dirty};

    xlat_entry_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_array (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .fill_en(fill_en), .fill_idx(victim_idx), .fill_vpn(fill_vpn),
        .fill_ppn(fill_ppn), .fill_flags(fill_flags), .mark_en(mark_en),
        .lk_vpn(lk_vpn), .valid_vec(valid_vec), .hit(hit),
        .hit_ppn(hit_ppn), .hit_flags(hit_flags)
    );

    xlat_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
        .clk(clk), .rst_n(rst_n), .flush(flush), .fill_en(fill_en),
        .valid_vec(valid_vec), .victim_idx(victim_idx)
    );

    xlat_perm_check u_perm (
        .is_write(lk_write), .is_user(lk_user), .flags(hit_flags), .allow(allow)
    );

    // Outcome decode: permitted hit, fault or miss, plus dirty reporting.
    always_comb begin
        pa_valid   = lk_valid & hit & allow;
        prot_fault = lk_valid & hit & ~allow;
        miss       = lk_valid & ~hit;
        hit_dirty  = lk_valid & hit & hit_flags.dty;
        pa_addr    = pa_valid ? {hit_ppn, lk_vaddr[OFF_W-1:0]} : '0;
        mark_en    = pa_valid & lk_write & ~hit_flags.dty;
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pa_valid, miss, prot_fault}));  // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(pa_valid || miss || prot_fault || hit_dirty));  // R9
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!lk_valid || miss));  // R8
    AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush) |=>
        (!lk_valid || lk_vpn != $past(fill_vpn) || !miss));  // R11
    AST_DIRTY_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_valid && lk_write && !flush && !fill_en) |=>
        ((!lk_valid || lk_vpn != $past(lk_vpn) || miss) || hit_dirty));  // R5
endmodule

// File: tb/xlat_cache_test.sv
module xlat_cache_test;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 16;
    localparam int VW  = 20;
    localparam int PW  = 20;
    localparam int OW  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 0, lk_write = 0, lk_user = 0;
    logic [VW+OW-1:0] lk_vaddr = '0;
    logic pa_valid, miss, prot_fault, hit_dirty;
    logic [PW+OW-1:0] pa_addr;
    logic fill_en = 0, fill_rd = 0, fill_wr = 0, fill_usr = 0, fill_dirty = 0, flush = 0;
    logic [VW-1:0] fill_vpn = '0;
    logic [PW-1:0] fill_ppn = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string req_tag = "R1";

    // Behavioural reference state
    bit     m_v [N];
    int     m_vpn [N];
    int     m_ppn [N];
    bit     m_r [N], m_w [N], m_u [N], m_d [N];
    int     m_ptr;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_cache uut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_write(lk_write), .lk_user(lk_user), .pa_valid(pa_valid),
        .pa_addr(pa_addr), .miss(miss), .prot_fault(prot_fault),
        .hit_dirty(hit_dirty), .fill_en(fill_en), .fill_vpn(fill_vpn),
        .fill_ppn(fill_ppn), .fill_rd(fill_rd), .fill_wr(fill_wr),
        .fill_usr(fill_usr), .fill_dirty(fill_dirty), .flush(flush)
    );

    function automatic int find_hit(int vpn);
        for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == vpn) return i;
        return -1;
    endfunction

    // Model update at each edge, mirroring the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_v[i] = 0; m_d[i] = 0; end
            m_ptr = 0;
        end else if (flush) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
            m_ptr = 0;
        end else begin
            int h;
            int slot;
            h = find_hit(int'(lk_vaddr[VW+OW-1:OW]));
            if (lk_valid && lk_write && h >= 0 && m_w[h] && (!lk_user || m_u[h]))
                m_d[h] = 1;
            if (fill_en) begin
                slot = -1;
                for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
                if (slot < 0) begin slot = m_ptr; m_ptr = (m_ptr + 1) % N; end
                m_v[slot] = 1; m_vpn[slot] = int'(fill_vpn); m_ppn[slot] = int'(fill_ppn);
                m_r[slot] = fill_rd; m_w[slot] = fill_wr; m_u[slot] = fill_usr;
                m_d[slot] = fill_dirty;
            end
        end
    end

    task automatic compare();
        int h;
        bit ok, e_pv, e_ms, e_pf, e_hd;
        logic [PW+OW-1:0] e_pa;
        h = find_hit(int'(lk_vaddr[VW+OW-1:OW]));
        ok = (h >= 0) && ((lk_write ? m_w[h] : m_r[h]) && (!lk_user || m_u[h]));
        e_pv = lk_valid && ok;
        e_pf = lk_valid && (h >= 0) && !ok;
        e_ms = lk_valid && (h < 0);
        e_hd = lk_valid && (h >= 0) && m_d[h];
        e_pa = e_pv ? {PW'(m_ppn[h]), lk_vaddr[OW-1:0]} : '0;
        checks++;
        if ({pa_valid, prot_fault, miss, hit_dirty} != {e_pv, e_pf, e_ms, e_hd} || pa_addr != e_pa) begin
            errors++;
            $display("FAIL %s t=%0t: pv/pf/ms/hd/pa=%b%b%b%b/%h expected %b%b%b%b/%h",
                     req_tag, $time, pa_valid, prot_fault, miss, hit_dirty, pa_addr,
                     e_pv, e_pf, e_ms, e_hd, e_pa);
        end
    endtask

    // One cycle: inputs already set after a falling edge; check, then advance.
    task automatic step();
        #(CLK_PERIOD/4);
        compare();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        lk_valid = 0; fill_en = 0; flush = 0; lk_write = 0; lk_user = 0;
    endtask

    task automatic look(int vpn, int off, bit wr, bit usr, string tag);
        idle_inputs();
        req_tag = tag;
        lk_valid = 1; lk_vaddr = {VW'(vpn), OW'(off)}; lk_write = wr; lk_user = usr;
        step();
    endtask

    task automatic fill(int vpn, int ppn, bit r, bit w, bit u, bit d, string tag);
        idle_inputs();
        req_tag = tag;
        fill_en = 1; fill_vpn = VW'(vpn); fill_ppn = PW'(ppn);
        fill_rd = r; fill_wr = w; fill_usr = u; fill_dirty = d;
        step();
    endtask

    task automatic do_flush(bit with_fill, int vpn, string tag);
        idle_inputs();
        req_tag = tag;
        flush = 1;
        if (with_fill) begin
            fill_en = 1; fill_vpn = VW'(vpn); fill_ppn = 20'h0ABCD;
            fill_rd = 1; fill_wr = 1; fill_usr = 1; fill_dirty = 0;
        end
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 1;
        // R1: empty after reset
        look(5, 12'h010, 0, 0, "R1");
        look(0, 0, 1, 1, "R1");
        // R9: idle
        idle_inputs(); req_tag = "R9"; step();
        // Refill a set of pages with different permissions (R6, R11)
        fill(16'h1000, 20'hA0001, 1, 1, 1, 0, "R6");
        look(16'h1000, 12'h123, 0, 1, "R11");
        fill(16'h1001, 20'hA0002, 1, 0, 1, 0, "R6");
        fill(16'h1002, 20'hA0003, 1, 1, 0, 0, "R6");
        fill(16'h1003, 20'hA0004, 0, 1, 1, 1, "R6");
        // R2: translation with offset kept
        look(16'h1000, 12'hFFF, 0, 0, "R2");
        look(16'h1001, 12'h000, 0, 1, "R2");
        // R4: permission matrix
        look(16'h1001, 12'h004, 1, 0, "R4");   // write to read-only
        look(16'h1002, 12'h008, 0, 1, "R4");   // user on kernel page
        look(16'h1002, 12'h008, 1, 0, "R4");   // kernel write ok
        look(16'h1003, 12'h00C, 0, 0, "R4");   // read on write-only
        look(16'h1003, 12'h00C, 1, 1, "R4");   // write ok, preset dirty
        // R3: miss on unknown page
        look(16'h7777, 12'h001, 0, 0, "R3");
        // R5: dirty set by permitted write, not by faulting write
        look(16'h1001, 12'h000, 1, 1, "R5");
        look(16'h1001, 12'h000, 0, 1, "R5");
        look(16'h1000, 12'h020, 0, 0, "R5");
        look(16'h1000, 12'h020, 1, 1, "R5");
        look(16'h1000, 12'h020, 0, 0, "R5");
        look(16'h1000, 12'h024, 1, 0, "R5");
        // R8: flush empties, with a fill in the same cycle
        do_flush(1, 16'h2222, "R8");
        look(16'h1000, 12'h020, 0, 0, "R8");
        look(16'h2222, 12'h020, 0, 0, "R8");
        // R6 then R7: fill exactly N, none evicted; then wrap the pointer
        for (int i = 0; i < N; i++) fill(200 + i, 300 + i, 1, 1, 1, 0, "R6");
        for (int i = 0; i < N; i++) look(200 + i, i, 0, 1, "R6");
        fill(216, 316, 1, 1, 1, 0, "R7");
        look(200, 1, 0, 0, "R7");
        look(201, 1, 0, 0, "R7");
        look(216, 1, 0, 0, "R7");
        for (int i = 17; i < 32; i++) fill(200 + i, 300 + i, 1, 1, 1, 0, "R7");
        fill(232, 332, 1, 1, 1, 0, "R7");
        look(216, 2, 0, 0, "R7");
        look(217, 2, 0, 0, "R7");
        look(232, 2, 0, 0, "R7");
        do_flush(0, 0, "R8");
        look(232, 2, 0, 0, "R8");
        // Randomised mix, R10 over all outcomes
        for (int k = 0; k < 3000; k++) begin
            int sel;
            int v;
            sel = int'($urandom_range(0, 99));
            v = 400 + int'($urandom_range(0, 23));
            if (sel < 25 && find_hit(v) < 0) begin
                fill(v, int'($urandom_range(0, 1048575)), 1'($urandom), 1'($urandom),
                     1'($urandom), 1'($urandom), "R10");
            end else if (sel == 99) begin
                do_flush(1'($urandom), 400 + int'($urandom_range(0, 23)), "R8");
            end else if (sel > 90) begin
                idle_inputs(); req_tag = "R9"; step();
            end else begin
                look(v, int'($urandom_range(0, 4095)), 1'($urandom), 1'($urandom), "R10");
            end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule